// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block captures a set of five frequency-select strap inputs exactly once, at the moment an active-low power-good strobe is first qualified low. It then holds them as a stable configuration word for the clock synthesizer. Once that capture has taken place, the same strobe pin serves a new purpose: it becomes a live, active-high power-down request. All inputs are asynchronous to the block clock and pass through a two-stage synchroniser before they are used.

Strap C is a three-level input. Its "above high threshold" condition reaches this block as a pre-digitised flag. When the flag is set at capture time, the block enters test mode, and strap B chooses the sub-mode. In test mode the one-shot lock is lifted. Every qualified low on the strobe captures the straps again, which lets a tester step through settings or leave test mode. An asynchronous reset clears the captured state and arms the capture again.

Top module: `strap_capture_ctl`

## Requirements
- R1: While reset is asserted and directly after it, `cfg_valid`, `pwr_down`, `test_mode` and `test_sub` are 0 and `sel_word` is all zeros.
- R2: A capture happens on the fourth rising clock edge after `pg_pin` falls, provided `pg_pin` stays low. That edge is two synchroniser stages plus two consecutive low samples. At capture, `sel_word[i]` takes strap i: bit 0 is strap A, bit 1 is B, bit 2 is C, bit 3 is D and bit 4 is E.
- R3: A low on `pg_pin` lasting a single clock cycle does not capture. `sel_word` and `cfg_valid` keep their values.
- R4: `cfg_valid` rises exactly one clock cycle after the captured word appears on `sel_word`.
- R5: Outside test mode, once a capture has happened, later changes on the straps and on `pg_pin` leave `sel_word` and `test_mode` unchanged.
- R6: `pwr_down` is 0 whenever `cfg_valid` is 0. When `cfg_valid` is 1, `pwr_down` follows the level on `pg_pin` (1 = power down) two clock edges later.
- R7: At capture, `test_mode` takes the value of `strap_c_hi`. `test_sub` takes strap B when in test mode and is 0 otherwise. A `test_sub` of 0 means all outputs tri-stated, and 1 means the reference clock is divided by N.
- R8: While `test_mode` is 1, every clock with a qualified low on the strobe captures the straps and `strap_c_hi` again. A new capture with `strap_c_hi` low leaves test mode, and from then on the lock holds.
- R9: Asserting `rst_n` clears the lock, so the next qualified low on the strobe captures new strap values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low; re-arms the capture |
| strap_in | input | 5 | Strap levels, bit 0 = A ... bit 4 = E |
| strap_c_hi | input | 1 | Strap C sits above the high threshold (test-mode request) |
| pg_pin | input | 1 | Power-good strobe (active low) before capture, power-down request (active high) after |
| sel_word | output | 5 | Captured strap word |
| cfg_valid | output | 1 | The captured word is valid |
| test_mode | output | 1 | Test mode is active |
| test_sub | output | 1 | Test sub-mode: 0 tri-state all, 1 reference divide |
| pwr_down | output | 1 | Live power-down request |

## Verification
The two functions that can land on the same clock are recapture in test mode and the power-down role of the pin. In test mode a low pin triggers a new capture, while a high pin has to drive `pwr_down`. The bench moves the straps while the pin is held low in test mode, then raises the pin. It checks that the word updates only while the pin is low and that `pwr_down` tracks the pin with its two-edge latency. A second overlap is the exit from test mode: the pin is held low while the straps change together with the threshold flag. The bench expects that capture to end test mode and every later strap change to be ignored.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_W = 5;
  localparam int IDX_B   = 1;

  typedef struct packed {
    logic active;
    logic sub;
  } tm_t;

  // Test-mode decode: sub-mode only meaningful while active.
  function automatic tm_t tm_decode(input logic c_hi, input logic b_lvl);
    tm_t r;
    r.active = c_hi;
    r.sub    = c_hi & b_lvl;
    return r;
  endfunction

  // Strobe counts as low only after two consecutive low samples.
  function automatic logic qual_low(input logic now_s, input logic prev_s);
    return (~now_s) & (~prev_s);
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int W = STRAP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pg_sync,
  input  logic [W-1:0] straps_sync,
  input  logic         c_hi_sync,
  output logic [W-1:0] sel_word,
  output logic         locked,
  output logic         test_mode,
  output logic         test_sub,
  output logic         capture_evt
);
  logic pg_d;
  tm_t  tm_next;

  assign tm_next     = tm_decode(c_hi_sync, straps_sync[IDX_B]);
  assign capture_evt = qual_low(pg_sync, pg_d) & (~locked | test_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d      <= 1'b1;
      sel_word  <= '0;
      locked    <= 1'b0;
      test_mode <= 1'b0;
      test_sub  <= 1'b0;
    end else begin
      pg_d <= pg_sync;
      if (capture_evt) begin
        sel_word  <= straps_sync;
        locked    <= 1'b1;
        test_mode <= tm_next.active;
        test_sub  <= tm_next.sub;
      end
    end
  end
endmodule

// File: rtl/strap_capture_ctl.sv
module strap_capture_ctl
  import strap_pkg::*;
#(
  parameter int W         = STRAP_W,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap_in,
  input  logic         strap_c_hi,
  input  logic         pg_pin,
  output logic [W-1:0] sel_word,
  output logic         cfg_valid,
  output logic         test_mode,
  output logic         test_sub,
  output logic         pwr_down
);
  localparam int SW = W + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, {W{1'b0}}};

  logic [SW-1:0] sync_out;
  logic [W-1:0]  straps_sync;
  logic          c_hi_sync;
  logic          pg_sync;
  logic          locked;
  logic          capture_evt;

  strap_sync #(.WIDTH(SW), .STAGES(SYNC_DEPTH), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({pg_pin, strap_c_hi, strap_in}),
    .d_out (sync_out)
  );

  assign straps_sync = sync_out[W-1:0];
  assign c_hi_sync   = sync_out[W];
  assign pg_sync     = sync_out[W+1];

  strap_latch #(.W(W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_sync     (pg_sync),
    .straps_sync (straps_sync),
    .c_hi_sync   (c_hi_sync),
    .sel_word    (sel_word),
    .locked      (locked),
    .test_mode   (test_mode),
    .test_sub    (test_sub),
    .capture_evt (capture_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_valid <= 1'b0;
    else        cfg_valid <= locked;
  end

  assign pwr_down = cfg_valid & pg_sync;
endmodule

// File: rtl/strap_capture_ctl_chk.sv
module strap_capture_ctl_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pg_pin,
  input logic         capture_evt,
  input logic         locked,
  input logic         cfg_valid,
  input logic         test_mode,
  input logic [W-1:0] sel_word,
  input logic         pwr_down
);
  // R2: a capture only follows two synchronised low samples of the pin
  assert_qual_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (!$past(pg_pin, 2) && !$past(pg_pin, 3)));

  // R4: first capture locks, valid flag follows one cycle later
  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_evt && !locked) |=> (locked ##1 cfg_valid));

  // R5: locked word and mode frozen outside test mode
  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !test_mode) |=> ($stable(sel_word) && !test_mode && cfg_valid));

  // R6: no power-down before the configuration is valid
  assert_pd_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> !pwr_down);
endmodule

bind strap_capture_ctl strap_capture_ctl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pg_pin      (pg_pin),
  .capture_evt (capture_evt),
  .locked      (locked),
  .cfg_valid   (cfg_valid),
  .test_mode   (test_mode),
  .sel_word    (sel_word),
  .pwr_down    (pwr_down)
);

// File: tb/strap_capture_ctl_test.sv
`timescale 1ns/1ps
module strap_capture_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] strap_in;
  logic       strap_c_hi;
  logic       pg_pin;
  logic [4:0] sel_word;
  logic       cfg_valid, test_mode, test_sub, pwr_down;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  strap_capture_ctl uut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_c_hi(strap_c_hi),
    .pg_pin(pg_pin), .sel_word(sel_word), .cfg_valid(cfg_valid),
    .test_mode(test_mode), .test_sub(test_sub), .pwr_down(pwr_down)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pg_pin = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  // Expected test sub-mode: B level only when the threshold flag is set.
  function automatic int exp_sub(input int straps, input int chi);
    return (chi != 0) ? ((straps >> 1) & 1) : 0;
  endfunction

  initial begin
    rst_n = 1'b0; strap_in = '0; strap_c_hi = 1'b0; pg_pin = 1'b0;
    cyc(2);
    // R1: reset state, pin low during reset
    check("R1 sel_word", sel_word, 0);
    check("R1 cfg_valid", cfg_valid, 0);
    check("R1 test_mode", test_mode, 0);
    check("R1 test_sub", test_sub, 0);
    check("R1 pwr_down", pwr_down, 0);

    // R2/R4/R7: exhaustive sweep over straps and threshold flag
    for (int v = 0; v < 64; v++) begin
      do_reset();
      strap_in = v[4:0]; strap_c_hi = v[5];
      cyc(3);
      pg_pin = 1'b0;
      cyc(3);
      check("R2 no early capture", cfg_valid, 0);
      cyc(1);
      check("R2 sel_word", sel_word, v & 31);
      check("R4 valid lags word", cfg_valid, 0);
      cyc(1);
      check("R4 cfg_valid", cfg_valid, 1);
      check("R7 test_mode", test_mode, (v >> 5) & 1);
      check("R7 test_sub", test_sub, exp_sub(v & 31, (v >> 5) & 1));
      check("R6 pin low no pd", pwr_down, 0);
    end

    // R3: single-cycle low glitch ignored; R6 pd gated before valid
    do_reset();
    strap_in = 5'b10101; strap_c_hi = 1'b0;
    cyc(3);
    pg_pin = 1'b0; cyc(1); pg_pin = 1'b1;
    cyc(8);
    check("R3 glitch cfg_valid", cfg_valid, 0);
    check("R3 glitch sel_word", sel_word, 0);
    check("R6 pd before valid", pwr_down, 0);

    // R5/R6: lock holds; pin becomes power-down
    do_reset();
    strap_in = 5'b10110; strap_c_hi = 1'b0;
    cyc(3);
    pg_pin = 1'b0; cyc(6);
    check("R5 captured", sel_word, 22);
    strap_in = 5'b01001; strap_c_hi = 1'b1;
    pg_pin = 1'b1;
    cyc(1);
    check("R6 pd latency", pwr_down, 0);
    cyc(1);
    check("R6 pd high", pwr_down, 1);
    pg_pin = 1'b0;
    cyc(2);
    check("R6 pd low", pwr_down, 0);
    cyc(6);
    check("R5 word locked", sel_word, 22);
    check("R5 no test entry", test_mode, 0);

    // R8: recapture in test mode, then exit and relock
    do_reset();
    strap_in = 5'b00010; strap_c_hi = 1'b1;
    cyc(3);
    pg_pin = 1'b0; cyc(6);
    check("R8 test entry", test_mode, 1);
    check("R8 sub ref-div", test_sub, 1);
    strap_in = 5'b00100;
    cyc(4);
    check("R8 recapture word", sel_word, 4);
    check("R8 sub tristate", test_sub, 0);
    pg_pin = 1'b1; strap_in = 5'b00110;
    cyc(2);
    check("R6 pd in test mode", pwr_down, 1);
    cyc(3);
    check("R8 no recapture while high", sel_word, 4);
    pg_pin = 1'b0;
    cyc(5);
    check("R8 recapture after low", sel_word, 6);
    strap_in = 5'b11001; strap_c_hi = 1'b0;
    cyc(4);
    check("R8 exit word", sel_word, 25);
    check("R8 exit mode", test_mode, 0);
    strap_in = 5'b00011;
    cyc(6);
    check("R8 relocked", sel_word, 25);

    // R9: reset re-arms the capture
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async clear word", sel_word, 0);
    check("R9 async clear valid", cfg_valid, 0);
    strap_in = 5'b01110;
    cyc(1);
    rst_n = 1'b1;
    cyc(6);
    check("R9 new capture", sel_word, 14);
    check("R9 valid again", cfg_valid, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule